// File: doc/BRIEF.md
# Integer Base ALU

A purely combinational 32-bit integer unit for the base RISC-V integer operations. It takes two operands, `op_a` and `op_b`, and a 4-bit operation code. From these it produces one 32-bit result within the same cycle. There are no registers inside it, so it fits directly into an execute stage between pipeline registers owned by the surrounding core.

The operation code follows the instruction encoding. Bits 2:0 carry the funct3 field, and bit 3 carries the alternate bit of funct7. A decoder can therefore pass instruction fields straight through. The data width is a parameter, and the shift-amount width is derived from it. At the default width of 32, only the low five bits of `op_b` steer the shifters.

Top module: `int_base_alu`

## Requirements
- R1: Code 4'b0000 returns op_a + op_b, wrapping modulo 2^32.
- R2: Code 4'b1000 returns op_a - op_b, wrapping modulo 2^32.
- R3: Code 4'b0001 returns op_a shifted left logically by op_b[4:0].
- R4: Code 4'b0101 returns op_a shifted right logically by op_b[4:0], filling with zeros.
- R5: Code 4'b1101 returns op_a shifted right arithmetically by op_b[4:0], filling with op_a[31].
- R6: For every shift, op_b[31:5] has no effect on the result.
- R7: Code 4'b0010 returns 1 when op_a < op_b as signed two's-complement values, otherwise 0.
- R8: Code 4'b0011 returns 1 when op_a < op_b as unsigned values, otherwise 0.
- R9: Set-less-than results are zero-extended, so bits 31:1 are always 0.
- R10: Codes 4'b0100, 4'b0110 and 4'b0111 return the bitwise XOR, OR and AND of op_a and op_b.
- R11: Every other code (4'b1001 to 4'b1100, 4'b1110, 4'b1111) returns 32'h0.
- R12: The result depends only on the present inputs; the block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand; low five bits give the shift amount |
| alu_op | input | 4 | Operation code: {funct7 alternate bit, funct3} |
| result | output | 32 | Computed result |

## Verification
The bench builds the unit at the default width of 32. At that width the shift amount is five bits, so shifts of 0 and 31 are the edges. The values 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF sit where the signed and unsigned orderings disagree and where addition and subtraction wrap. Each of these corners, plus random operands, is applied to all sixteen codes, including the unused ones. For every shift, the same operation is repeated with a different op_b[31:5] to show that those upper bits have no effect.

// File: rtl/int_base_alu.sv
module int_base_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [3:0]      alu_op,
  output logic [XLEN-1:0] result
);
  localparam int SHW = $clog2(XLEN);

  localparam logic [3:0] OP_ADD  = 4'b0000;
  localparam logic [3:0] OP_SLL  = 4'b0001;
  localparam logic [3:0] OP_SLT  = 4'b0010;
  localparam logic [3:0] OP_SLTU = 4'b0011;
  localparam logic [3:0] OP_XOR  = 4'b0100;
  localparam logic [3:0] OP_SRL  = 4'b0101;
  localparam logic [3:0] OP_OR   = 4'b0110;
  localparam logic [3:0] OP_AND  = 4'b0111;
  localparam logic [3:0] OP_SUB  = 4'b1000;
  localparam logic [3:0] OP_SRA  = 4'b1101;

  logic [SHW-1:0]  shamt;
  logic [XLEN-1:0] sum, diff, shl, shr_l, shr_a;
  logic            lt_s, lt_u;

  assign shamt = op_b[SHW-1:0];
  assign sum   = op_a + op_b;
  assign diff  = op_a - op_b;
  assign shl   = op_a << shamt;
  assign shr_l = op_a >> shamt;
  assign shr_a = XLEN'($signed(op_a) >>> shamt);
  assign lt_s  = $signed(op_a) < $signed(op_b);
  assign lt_u  = op_a < op_b;

  always_comb begin
    unique case (alu_op)
      OP_ADD:  result = sum;
      OP_SUB:  result = diff;
      OP_SLL:  result = shl;
      OP_SRL:  result = shr_l;
      OP_SRA:  result = shr_a;
      OP_SLT:  result = {{(XLEN-1){1'b0}}, lt_s};
      OP_SLTU: result = {{(XLEN-1){1'b0}}, lt_u};
      OP_XOR:  result = op_a ^ op_b;
      OP_OR:   result = op_a | op_b;
      OP_AND:  result = op_a & op_b;
      default: result = '0;
    endcase
  end

  always_comb begin
    if (alu_op == OP_SLT || alu_op == OP_SLTU)
      assert_slt_zext_R9: assert (result[XLEN-1:1] == '0);
    if (alu_op == OP_ADD)
      assert_add_inverse_R1: assert (result - op_b == op_a);
    if (alu_op == OP_SUB)
      assert_sub_inverse_R2: assert (result + op_b == op_a);
    if (alu_op == OP_SRA)
      assert_sra_sign_R5: assert (result[XLEN-1] == op_a[XLEN-1]);
    if (alu_op == OP_SRL && shamt != '0)
      assert_srl_zero_fill_R4: assert (result[XLEN-1] == 1'b0);
    if (alu_op == OP_SLL && shamt != '0)
      assert_sll_zero_fill_R3: assert (result[0] == 1'b0);
    if (alu_op[3] && alu_op != OP_SUB && alu_op != OP_SRA)
      assert_unused_zero_R11: assert (result == '0);
    if (alu_op == OP_SLTU)
      assert_sltu_order_R8: assert (result[0] == (op_a < op_b));
  end
endmodule

// File: tb/test_int_base_alu.sv
module test_int_base_alu;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] op_a, op_b, result;
  logic [3:0]  alu_op;
  int n_cmp = 0, n_bad = 0;
  bit  done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t q[$];

  int_base_alu i_int_base_alu (.op_a(op_a), .op_b(op_b), .alu_op(alu_op), .result(result));

  function automatic logic [31:0] ref_model(logic [31:0] a, logic [31:0] b, logic [3:0] op);
    int sh;
    logic [31:0] r;
    sh = int'(b % 32);
    case (op)
      4'b0000: return a + b;
      4'b1000: return a + ~b + 32'd1;
      4'b0001: begin r = a; for (int i = 0; i < sh; i++) r = {r[30:0], 1'b0}; return r; end
      4'b0101: begin r = a; for (int i = 0; i < sh; i++) r = {1'b0, r[31:1]}; return r; end
      4'b1101: begin r = a; for (int i = 0; i < sh; i++) r = {r[31], r[31:1]}; return r; end
      4'b0010: begin
        if (a[31] != b[31]) return {31'd0, a[31]};
        return {31'd0, a < b};
      end
      4'b0011: return {31'd0, a < b};
      4'b0100: return a ^ b;
      4'b0110: return a | b;
      4'b0111: return a & b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b1000: return "R2";
      4'b0001: return "R3";
      4'b0101: return "R4";
      4'b1101: return "R5";
      4'b0010: return "R7/R9";
      4'b0011: return "R8/R9";
      4'b0100, 4'b0110, 4'b0111: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op, input string tag);
    item_t it;
    @(posedge clk);
    op_a = a; op_b = b; alu_op = op;
    it.exp = ref_model(a, b, op);
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_cmp++;
      if (result !== it.exp) begin
        n_bad++;
        $display("FAIL %s: op=%b a=%h b=%h actual=%h expected=%h", it.tag, alu_op, op_a, op_b, result, it.exp);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  logic [31:0] corners [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};

  initial begin
    op_a = '0; op_b = '0; alu_op = '0;
    // R12: stateless, inputs at rest give 0 + 0
    drive(32'h0, 32'h0, 4'b0000, "R12");
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(corners[i], corners[j], 4'(op), tag_of(4'(op)));
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      for (int op = 0; op < 16; op++) drive(a, b, 4'(op), tag_of(4'(op)));
    end
    // R6: upper op_b bits ignored; shifts of 0 and 31
    for (int k = 0; k < 40; k++) begin
      logic [31:0] a, hi;
      a = (k < 5) ? corners[k] : $urandom;
      hi = $urandom;
      foreach (corners[c]) begin end
      drive(a, {hi[26:0], 5'd0},  4'b0001, "R6");
      drive(a, {hi[26:0], 5'd31}, 4'b0001, "R6");
      drive(a, {hi[26:0], 5'd31}, 4'b0101, "R6");
      drive(a, {hi[26:0], 5'd0},  4'b0101, "R6");
      drive(a, {hi[26:0], 5'd31}, 4'b1101, "R6");
      drive(a, {hi[26:0], 5'd0},  4'b1101, "R6");
      drive(a, {~hi[26:0], 5'd7}, 4'b1101, "R6");
    end
    // R12: same inputs after other traffic give the same answer
    drive(32'h12345678, 32'h0000000F, 4'b0000, "R12");
    drive(32'hFFFFFFFF, 32'h00000001, 4'b0011, "R12");
    drive(32'h12345678, 32'h0000000F, 4'b0000, "R12");
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule